// File: doc/BRIEF.md
# Registered One-Time-Programmable Byte Memory with Initialize Word

This block models a write-once byte memory whose read data passes through an output register. An address selects one of the stored bytes, and the rising clock edge copies that byte into the register that drives the data outputs. A separate initialize input, active low, substitutes one extra programmable word for the register contents at once, without waiting for a clock. This word can serve as a preset or clear value, or as a start-up word.

A one-bit configuration chooses how output enable works. In the immediate mode the enable pin gates the drive directly. In the clocked mode the enable pin is sampled at the rising clock edge. Drive is shown on a separate enable output that stands in for tri-state.

A digital programming port writes three targets, each picked by a select code: an array byte, the initialize word, or the enable-mode bit. Every write ORs the new data into the stored value, so a bit can be set but never cleared. Storage starts erased after reset.

Top module: `regrom_top`

## Requirements
- R1: After reset every array byte and the initialize word read 0, the data output is 0, the mode is immediate enable, and with the enable pin high the drive output is 0.
- R2: With initialize inactive, the data output takes the byte at the current address at each rising clock edge. It holds that value between edges, so a byte appears one edge after its address is applied.
- R3: When the programming strobe is high at a rising edge with select code 0, the data is ORed into the array byte at the programming address. A bit that has been set is never cleared.
- R4: When the programming strobe is high at a rising edge with select code 1, the data is ORed into the initialize word.
- R5: While the initialize input is low, the data output shows the initialize word at once, and clock edges do not change it.
- R6: After the initialize input returns high, the initialize word stays on the data output until the next rising edge. That edge loads the byte at the current address.
- R7: In immediate mode the drive output is the inverse of the enable pin and follows it without waiting for a clock.
- R8: When the programming strobe is high at a rising edge with select code 2, clocked mode is selected whatever the data value. The mode cannot return to immediate until reset.
- R9: In clocked mode the drive output changes only at rising edges. It becomes 1 at an edge where the enable pin is low and 0 at an edge where the pin is high.
- R10: Select code 3, or any write attempt with the strobe low, changes no array byte, the initialize word or the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; output register and programming act on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; erases all storage |
| addr | input | 11 | Read address |
| init_n | input | 1 | Initialize request, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low |
| prog_en | input | 1 | Programming strobe |
| prog_sel | input | 2 | Target: 0 array byte, 1 initialize word, 2 mode bit, 3 none |
| prog_addr | input | 11 | Array byte address for programming |
| prog_data | input | 8 | Data ORed into the target |
| dout | output | 8 | Data output |
| dout_en | output | 1 | Drive indication; 0 stands for high impedance |

## Verification
A corrupted array row or a missed OR shows on the data output one edge after that address is swept. A stuck mode bit appears as a drive output that follows the enable pin between edges when it should wait, or that waits when it should follow. A bad initialize holding flag shows either as array data leaking through while the request is held, or as a missing initialize word in the half cycle after release. Each of these is visible within a single clock of the stimulus that exposes it.

// File: rtl/regrom_pkg.sv
package regrom_pkg;

   typedef enum logic [1:0] {
      PSEL_ARRAY = 2'd0,
      PSEL_INIT  = 2'd1,
      PSEL_MODE  = 2'd2,
      PSEL_NONE  = 2'd3
   } psel_t;

endpackage

// File: rtl/regrom_array.sv
module regrom_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH*DATA_W-1:0] flat_q;

   // One row of storage per word; a write sets bits only.
   for (genvar g = 0; g < DEPTH; g++) begin : gen_row
      logic [DATA_W-1:0] cell_q;
      logic              hit;

      assign hit = wr_en && (wr_addr == ADDR_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q <= '0;
         end else if (hit) begin
            cell_q <= cell_q | wr_data;
         end
      end

      assign flat_q[g*DATA_W +: DATA_W] = cell_q;
   end

   assign rd_data = flat_q[int'(rd_addr)*DATA_W +: DATA_W];

endmodule

// File: rtl/regrom_cfg.sv
module regrom_cfg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_init,
   input  logic              wr_mode,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] init_word,
   output logic              sync_mode
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_word <= '0;
      end else if (wr_init) begin
         init_word <= init_word | wr_data;
      end
   end

   // Mode bit carries no data: a write only sets it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_mode <= 1'b0;
      end else if (wr_mode) begin
         sync_mode <= 1'b1;
      end
   end

endmodule

// File: rtl/regrom_outreg.sv
module regrom_outreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_n,
   input  logic [DATA_W-1:0] init_word,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              sync_mode,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   logic [DATA_W-1:0] data_q;
   logic              hold_q;
   logic              en_q;

   // Set at once by the initialize request, cleared by the first edge after it ends.
   always_ff @(posedge clk or negedge rst_n or negedge init_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
      end else if (!init_n) begin
         hold_q <= 1'b1;
      end else begin
         hold_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (init_n) begin
         data_q <= rd_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else begin
         en_q <= !oe_n;
      end
   end

   assign dout    = (hold_q || !init_n) ? init_word : data_q;
   assign dout_en = sync_mode ? en_q : !oe_n;

endmodule

// File: rtl/regrom_top.sv
module regrom_top #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              init_n,
   input  logic              oe_n,
   input  logic              prog_en,
   input  logic [1:0]        prog_sel,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [DATA_W-1:0] prog_data,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   import regrom_pkg::*;

   if (ADDR_W < 1 || ADDR_W > 12) begin : gen_bad_addr
      $error("regrom_top: ADDR_W must be in 1..12");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : gen_bad_data
      $error("regrom_top: DATA_W must be in 1..64");
   end

   psel_t             sel;
   logic              wr_arr;
   logic              wr_init;
   logic              wr_mode;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] init_word;
   logic              sync_mode;

   assign sel     = psel_t'(prog_sel);
   assign wr_arr  = prog_en && (sel == PSEL_ARRAY);
   assign wr_init = prog_en && (sel == PSEL_INIT);
   assign wr_mode = prog_en && (sel == PSEL_MODE);

   regrom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_arr),
      .wr_addr (prog_addr),
      .wr_data (prog_data),
      .rd_addr (addr),
      .rd_data (rd_data)
   );

   regrom_cfg #(.DATA_W(DATA_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_init   (wr_init),
      .wr_mode   (wr_mode),
      .wr_data   (prog_data),
      .init_word (init_word),
      .sync_mode (sync_mode)
   );

   regrom_outreg #(.DATA_W(DATA_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_n    (init_n),
      .init_word (init_word),
      .rd_data   (rd_data),
      .sync_mode (sync_mode),
      .oe_n      (oe_n),
      .dout      (dout),
      .dout_en   (dout_en)
   );

endmodule

// File: rtl/regrom_chk.sv
module regrom_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              init_n,
   input logic              oe_n,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en,
   input logic [DATA_W-1:0] init_word,
   input logic              sync_mode
);

   p_async_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_mode |-> (dout_en == !oe_n));

   p_sync_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sync_mode |=> (dout_en == $past(!oe_n)));

   p_mode_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_mode |=> sync_mode);

   p_init_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(init_word) & ~init_word) == '0));

   p_init_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !init_n |-> (dout == init_word));

   p_release_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !init_n |=> (dout == init_word));

endmodule

bind regrom_top regrom_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .init_n    (init_n),
   .oe_n      (oe_n),
   .dout      (dout),
   .dout_en   (dout_en),
   .init_word (init_word),
   .sync_mode (sync_mode)
);

// File: tb/sim_regrom_top.sv
module sim_regrom_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          init_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          prog_en = 1'b0;
   logic [1:0]    prog_sel = 2'd0;
   logic [AW-1:0] prog_addr = '0;
   logic [DW-1:0] prog_data = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   int vectors = 0;
   int errors = 0;
   logic [DW-1:0] exp_mem [DEPTH];
   logic [DW-1:0] exp_init;

   regrom_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic prog(input logic [1:0] s, input logic [AW-1:0] a, input logic [DW-1:0] d);
      prog_en = 1'b1; prog_sel = s; prog_addr = a; prog_data = d;
      tick();
      prog_en = 1'b0;
   endtask

   function automatic logic [DW-1:0] pat_a(input int a);
      return DW'((a * 29 + 3) & 255);
   endfunction

   function automatic logic [DW-1:0] pat_b(input int a);
      return DW'(((a >> 3) ^ 8'h11) & 255);
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
      exp_init = '0;
      #(CLK_PERIOD*2 + 1);
      // R1: reset state
      check(dout == 0, "R1 dout at reset", dout, 0);
      check(dout_en == 0, "R1 drive at reset", dout_en, 0);
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R7: immediate enable
      oe_n = 1'b0; #1;
      check(dout_en == 1, "R7 enable low drives", dout_en, 1);
      oe_n = 1'b1; #1;
      check(dout_en == 0, "R7 enable high releases", dout_en, 0);
      oe_n = 1'b0;
      // R1: blank array sweep
      for (int a = 0; a < DEPTH; a += 7) begin
         addr = AW'(a);
         tick();
         check(dout == 0, "R1 blank byte", dout, 0);
      end
      check(dout_en == 1, "R7 still driven", dout_en, 1);
      // R3: two OR passes over the whole array
      for (int a = 0; a < DEPTH; a++) begin
         prog(2'd0, AW'(a), pat_a(a));
         exp_mem[a] = pat_a(a);
      end
      for (int a = 0; a < DEPTH; a++) begin
         prog(2'd0, AW'(a), pat_b(a));
         exp_mem[a] = exp_mem[a] | pat_b(a);
      end
      // R2: registered read, one edge latency
      addr = '0;
      tick();
      for (int a = 1; a < DEPTH; a++) begin
         addr = AW'(a); #1;
         check(dout == exp_mem[a-1], "R2 holds between edges", dout, exp_mem[a-1]);
         tick();
         check(dout == exp_mem[a], "R3 OR-programmed byte", dout, exp_mem[a]);
      end
      // R4: initialize word programmed twice
      prog(2'd1, '0, 8'hA4);
      prog(2'd1, '0, 8'h0F);
      exp_init = 8'hA4 | 8'h0F;
      // R5: immediate init, edges ignored
      addr = AW'(10);
      tick();
      init_n = 1'b0; #1;
      check(dout == exp_init, "R5 init immediate", dout, exp_init);
      check(dout == exp_init, "R4 init word OR", dout, exp_init);
      for (int k = 0; k < 4; k++) begin
         addr = AW'(200 + k);
         tick();
         check(dout == exp_init, "R5 edges do not overwrite", dout, exp_init);
      end
      // R6: release holds until the next edge
      addr = AW'(100);
      init_n = 1'b1; #1;
      check(dout == exp_init, "R6 held after release", dout, exp_init);
      tick();
      check(dout == exp_mem[100], "R6 first edge loads array", dout, exp_mem[100]);
      // R10: code 3 and strobe low do nothing
      prog(2'd3, AW'(100), 8'hFF);
      prog_en = 1'b0; prog_sel = 2'd0; prog_addr = AW'(101); prog_data = 8'hFF;
      tick();
      prog_sel = 2'd1;
      tick();
      prog_sel = 2'd2;
      tick();
      addr = AW'(100);
      tick();
      check(dout == exp_mem[100], "R10 code 3 no array write", dout, exp_mem[100]);
      addr = AW'(101);
      tick();
      check(dout == exp_mem[101], "R10 strobe low no write", dout, exp_mem[101]);
      init_n = 1'b0; #1;
      check(dout == exp_init, "R10 init word unchanged", dout, exp_init);
      init_n = 1'b1;
      tick();
      oe_n = 1'b1; #1;
      check(dout_en == 0, "R10 mode still immediate", dout_en, 0);
      oe_n = 1'b0; #1;
      check(dout_en == 1, "R7 immediate again", dout_en, 1);
      // R8: select clocked mode with zero data
      prog(2'd2, '0, 8'h00);
      check(dout_en == 1, "R9 driven after edge with enable low", dout_en, 1);
      oe_n = 1'b1; #1;
      check(dout_en == 1, "R8 clocked mode selected", dout_en, 1);
      check(dout_en == 1, "R9 no change between edges", dout_en, 1);
      tick();
      check(dout_en == 0, "R9 released at edge", dout_en, 0);
      oe_n = 1'b0; #1;
      check(dout_en == 0, "R9 stays released", dout_en, 0);
      tick();
      check(dout_en == 1, "R9 driven at edge", dout_en, 1);
      prog(2'd2, '0, 8'hFF);
      oe_n = 1'b1; #1;
      check(dout_en == 1, "R8 mode sticky", dout_en, 1);
      tick();
      check(dout_en == 0, "R9 edge sample", dout_en, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule